// File: doc/BRIEF.md
# Translation Fault Status Encoder

This block sits after an address translation unit. When a translation attempt ends, the unit raises a one-cycle fault strobe along with a result code, the access class, a direct-store access subtype and the effective address. The encoder turns that combination into an exception selection and the status words that the exception handler will read. It then captures them into registers on the clock edge that samples the strobe.

Instruction-side faults produce an error code. Data-side faults produce a status word and capture the faulting address. Direct-store faults are split further by access subtype. Some of them are sent to the alignment exception instead of the data storage exception. Result codes the encoder does not know are reported as a program exception of the invalid-operation kind.

Every output register holds its value until a later strobe carries a fault that writes it. A strobe that reports a successful translation changes nothing.

Top module: `xlat_fault_enc`

## Requirements
- R1: After reset, `exc_sel` is 0 (none) and `err_code`, `data_stat` and `fault_addr` are all zero.
- R2: The outputs change only on a clock edge that samples `fault_stb` high with a non-zero `xlat_res`. Without a strobe, or with `xlat_res` = 0 (success), every output keeps its value.
- R3: For `acc_class` 0 (fetch) with `xlat_res` 1 (miss), `exc_sel` becomes 1 (instruction storage) and `err_code` becomes 0x40000000. The outputs update one cycle after the strobe.
- R4: For a fetch, `xlat_res` 2 (protection) gives `err_code` 0x08000000. `xlat_res` 3 (no-execute) or 4 (direct-store) gives 0x10000000. In all three cases `exc_sel` is 1.
- R5: For a data access with `xlat_res` 1, `exc_sel` becomes 2 (data storage) and `fault_addr` captures `fault_va`. `data_stat` becomes 0x40000000 for a load (`acc_class` 1 or 3) and 0x42000000 for a store (`acc_class` 2). Bit 25 is the store qualifier.
- R6: For a data access with `xlat_res` 2, `exc_sel` is 2 and `data_stat` is 0x08000000 for a load or 0x0A000000 for a store. `fault_addr` captures the address.
- R7: A data access with `xlat_res` 4 and `ds_kind` 1 (floating-point) sets `exc_sel` 3 (alignment), sets `err_code` to 0x00000001 and captures the address.
- R8: A data access with `xlat_res` 4 and `ds_kind` 2 (reservation) sets `exc_sel` 2 with `data_stat` 0x04000000 for a load or 0x06000000 for a store. With `ds_kind` 0 (integer) or 3 (cache/external control), `data_stat` is 0x04100000 for a load or 0x06100000 for a store. `fault_addr` captures the address in both cases.
- R9: `xlat_res` 5, 6 or 7 on any access, or `xlat_res` 3 on a data access, sets `exc_sel` 4 (program), sets `err_code` to 0x00000020 and captures the address.
- R10: A fault writes only its own registers. An instruction storage fault leaves `data_stat` and `fault_addr` unchanged. A data storage fault leaves `err_code` unchanged. Alignment and program faults leave `data_stat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_stb | input | 1 | Translation result valid, one cycle |
| xlat_res | input | 3 | Result code: 0 ok, 1 miss, 2 protection, 3 no-execute, 4 direct-store, 5-7 unknown |
| acc_class | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| ds_kind | input | 2 | Direct-store subtype: 0 integer, 1 floating, 2 reservation, 3 cache/external |
| fault_va | input | ADDR_W | Faulting effective address |
| exc_sel | output | 3 | 0 none, 1 instruction storage, 2 data storage, 3 alignment, 4 program |
| err_code | output | 32 | Instruction-side, alignment or program code |
| data_stat | output | 32 | Data-side status word |
| fault_addr | output | ADDR_W | Captured faulting address |

## Verification
The bench pairs each cause with both load and store classes. A design that dropped the store qualifier would report load status words on stores. Faults are interleaved so that a fetch fault follows a data fault and the reverse. A design that cleared or wrote registers outside its own fault class would show a changed `data_stat` or `fault_addr` after a fetch fault. Success strobes and idle cycles are placed between faults, so any design that captures on the strobe alone would lose the held values. Every direct-store subtype and every unknown result code is applied. This exposes routing errors such as a floating-point direct-store access reaching data storage, or a data no-execute result being treated as a protection fault.

// File: rtl/xlat_fault_pkg.sv
package xlat_fault_pkg;

  localparam logic [2:0] RES_OK     = 3'd0;
  localparam logic [2:0] RES_MISS   = 3'd1;
  localparam logic [2:0] RES_PROT   = 3'd2;
  localparam logic [2:0] RES_NOEXEC = 3'd3;
  localparam logic [2:0] RES_DSTORE = 3'd4;

  localparam logic [1:0] CLS_FETCH = 2'd0;
  localparam logic [1:0] CLS_STORE = 2'd2;

  localparam logic [1:0] DSK_INT  = 2'd0;
  localparam logic [1:0] DSK_FP   = 2'd1;
  localparam logic [1:0] DSK_RSV  = 2'd2;
  localparam logic [1:0] DSK_EXT  = 2'd3;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_ISTOR = 3'd1,
    EXC_DSTOR = 3'd2,
    EXC_ALIGN = 3'd3,
    EXC_PROG  = 3'd4
  } exc_e;

  localparam logic [31:0] ST_MISS   = 32'h4000_0000;
  localparam logic [31:0] ST_NOEXEC = 32'h1000_0000;
  localparam logic [31:0] ST_PROT   = 32'h0800_0000;
  localparam logic [31:0] ST_DSEG   = 32'h0400_0000;
  localparam logic [31:0] ST_STORE  = 32'h0200_0000;
  localparam logic [31:0] ST_EXTCTL = 32'h0010_0000;

  localparam logic [31:0] CODE_ALIGN_FP = 32'h0000_0001;
  localparam logic [31:0] CODE_INVAL    = 32'h0000_0020;

  typedef struct packed {
    exc_e        exc;
    logic [31:0] code;
    logic [31:0] stat;
    logic        we_exc;
    logic        we_code;
    logic        we_stat;
    logic        we_addr;
  } fault_dec_t;

endpackage

// File: rtl/xlat_fault_decode.sv
module xlat_fault_decode
  import xlat_fault_pkg::*;
(
  input  logic [2:0] res,
  input  logic [1:0] cls,
  input  logic [1:0] kind,
  output fault_dec_t dec
);

  logic        is_fetch;
  logic [31:0] store_q;

  always_comb begin
    is_fetch = (cls == CLS_FETCH);
    store_q  = (cls == CLS_STORE) ? ST_STORE : 32'h0;
    dec      = '{exc: EXC_NONE, code: 32'h0, stat: 32'h0,
                 we_exc: 1'b0, we_code: 1'b0, we_stat: 1'b0, we_addr: 1'b0};
    if (res != RES_OK) begin
      dec.we_exc = 1'b1;
      if (is_fetch && (res <= RES_DSTORE)) begin
        dec.exc     = EXC_ISTOR;
        dec.we_code = 1'b1;
        unique case (res)
          RES_MISS: dec.code = ST_MISS;
          RES_PROT: dec.code = ST_PROT;
          default:  dec.code = ST_NOEXEC;
        endcase
      end else if (!is_fetch && (res == RES_MISS || res == RES_PROT)) begin
        dec.exc     = EXC_DSTOR;
        dec.we_stat = 1'b1;
        dec.we_addr = 1'b1;
        dec.stat    = ((res == RES_MISS) ? ST_MISS : ST_PROT) | store_q;
      end else if (!is_fetch && res == RES_DSTORE && kind == DSK_FP) begin
        dec.exc     = EXC_ALIGN;
        dec.we_code = 1'b1;
        dec.we_addr = 1'b1;
        dec.code    = CODE_ALIGN_FP;
      end else if (!is_fetch && res == RES_DSTORE) begin
        dec.exc     = EXC_DSTOR;
        dec.we_stat = 1'b1;
        dec.we_addr = 1'b1;
        dec.stat    = ST_DSEG | store_q | ((kind == DSK_RSV) ? 32'h0 : ST_EXTCTL);
      end else begin
        dec.exc     = EXC_PROG;
        dec.we_code = 1'b1;
        dec.we_addr = 1'b1;
        dec.code    = CODE_INVAL;
      end
    end
  end

endmodule

// File: rtl/xlat_fault_regs.sv
module xlat_fault_regs
  import xlat_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  fault_dec_t        dec,
  input  logic [ADDR_W-1:0] va,
  output exc_e              exc_q,
  output logic [31:0]       code_q,
  output logic [31:0]       stat_q,
  output logic [ADDR_W-1:0] addr_q
);

  exc_e              exc_d;
  logic [31:0]       code_d;
  logic [31:0]       stat_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    exc_d  = exc_q;
    code_d = code_q;
    stat_d = stat_q;
    addr_d = addr_q;
    if (stb) begin
      if (dec.we_exc)  exc_d  = dec.exc;
      if (dec.we_code) code_d = dec.code;
      if (dec.we_stat) stat_d = dec.stat;
      if (dec.we_addr) addr_d = va;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q  <= EXC_NONE;
      code_q <= '0;
      stat_q <= '0;
      addr_q <= '0;
    end else begin
      exc_q  <= exc_d;
      code_q <= code_d;
      stat_q <= stat_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/xlat_fault_enc.sv
module xlat_fault_enc
  import xlat_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_stb,
  input  logic [2:0]        xlat_res,
  input  logic [1:0]        acc_class,
  input  logic [1:0]        ds_kind,
  input  logic [ADDR_W-1:0] fault_va,
  output logic [2:0]        exc_sel,
  output logic [31:0]       err_code,
  output logic [31:0]       data_stat,
  output logic [ADDR_W-1:0] fault_addr
);

  fault_dec_t dec;
  exc_e       exc_q;

  xlat_fault_decode u_decode (
    .res  (xlat_res),
    .cls  (acc_class),
    .kind (ds_kind),
    .dec  (dec)
  );

  xlat_fault_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (fault_stb),
    .dec    (dec),
    .va     (fault_va),
    .exc_q  (exc_q),
    .code_q (err_code),
    .stat_q (data_stat),
    .addr_q (fault_addr)
  );

  assign exc_sel = exc_q;

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_stb || xlat_res == RES_OK) |=>
      ($stable(exc_sel) && $stable(err_code) && $stable(data_stat) && $stable(fault_addr)));

  assert_fetch_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stb && acc_class == CLS_FETCH && xlat_res == RES_MISS) |=>
      (exc_sel == 3'd1 && err_code == 32'h4000_0000));

  assert_store_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stb && acc_class == CLS_STORE && xlat_res == RES_MISS) |=>
      (data_stat == 32'h4200_0000 && fault_addr == $past(fault_va)));

  assert_fp_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stb && acc_class != CLS_FETCH && xlat_res == RES_DSTORE && ds_kind == DSK_FP) |=>
      (exc_sel == 3'd3 && err_code == 32'h0000_0001));

  assert_unknown_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stb && xlat_res > RES_DSTORE) |=> (exc_sel == 3'd4 && err_code == 32'h0000_0020));

  assert_fetch_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stb && acc_class == CLS_FETCH && xlat_res != RES_OK && xlat_res <= RES_DSTORE) |=>
      ($stable(data_stat) && $stable(fault_addr)));

  assert_exc_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_sel <= 3'd4);

endmodule

// File: tb/xlat_fault_enc_tb.sv
module xlat_fault_enc_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fault_stb = 1'b0;
  logic [2:0]    xlat_res = '0;
  logic [1:0]    acc_class = '0;
  logic [1:0]    ds_kind = '0;
  logic [AW-1:0] fault_va = '0;
  logic [2:0]    exc_sel;
  logic [31:0]   err_code;
  logic [31:0]   data_stat;
  logic [AW-1:0] fault_addr;

  always #4 clk = ~clk;

  xlat_fault_enc #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fault_stb(fault_stb), .xlat_res(xlat_res),
    .acc_class(acc_class), .ds_kind(ds_kind), .fault_va(fault_va),
    .exc_sel(exc_sel), .err_code(err_code), .data_stat(data_stat),
    .fault_addr(fault_addr)
  );

  typedef struct {
    logic [2:0]    exc;
    logic [31:0]   code;
    logic [31:0]   stat;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t mdl;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic cmp(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic check_now(input exp_t e);
    n_vec++;
    cmp(e.tag, "exc_sel", {29'h0, exc_sel}, {29'h0, e.exc});
    cmp(e.tag, "err_code", err_code, e.code);
    cmp(e.tag, "data_stat", data_stat, e.stat);
    cmp(e.tag, "fault_addr", fault_addr, e.addr);
  endtask

  // driver: one strobe (or idle) per cycle, expected item from the requirements
  task automatic apply(input bit stb, input logic [2:0] r, input logic [1:0] c,
                       input logic [1:0] k, input logic [AW-1:0] a, input string tag);
    logic [31:0] sq;
    @(negedge clk);
    fault_stb = stb; xlat_res = r; acc_class = c; ds_kind = k; fault_va = a;
    sq = (c == 2'd2) ? 32'h0200_0000 : 32'h0;
    mdl.tag = tag;
    if (stb && r != 3'd0) begin
      if (c == 2'd0 && r <= 3'd4) begin
        mdl.exc = 3'd1;
        mdl.code = (r == 3'd1) ? 32'h4000_0000 : (r == 3'd2) ? 32'h0800_0000 : 32'h1000_0000;
      end else if (c != 2'd0 && (r == 3'd1 || r == 3'd2)) begin
        mdl.exc = 3'd2; mdl.addr = a;
        mdl.stat = ((r == 3'd1) ? 32'h4000_0000 : 32'h0800_0000) | sq;
      end else if (c != 2'd0 && r == 3'd4 && k == 2'd1) begin
        mdl.exc = 3'd3; mdl.code = 32'h0000_0001; mdl.addr = a;
      end else if (c != 2'd0 && r == 3'd4) begin
        mdl.exc = 3'd2; mdl.addr = a;
        mdl.stat = ((k == 2'd2) ? 32'h0400_0000 : 32'h0410_0000) | sq;
      end else begin
        mdl.exc = 3'd4; mdl.code = 32'h0000_0020; mdl.addr = a;
      end
    end
    q.push_back(mdl);
  endtask

  // monitor: pop and compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) check_now(q.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    mdl = '{exc: 3'd0, code: 32'h0, stat: 32'h0, addr: '0, tag: "R1"};
    repeat (3) @(negedge clk);
    check_now(mdl);                                   // R1 reset values
    rst_n = 1'b1;
    apply(0, 3'd0, 2'd0, 2'd0, 32'h0, "R1");          // R1 still reset after release
    apply(1, 3'd1, 2'd0, 2'd0, 32'h1000_1000, "R3");  // fetch miss
    apply(1, 3'd1, 2'd1, 2'd0, 32'hA000_0004, "R5");  // load miss
    apply(1, 3'd2, 2'd0, 2'd0, 32'h5555_0000, "R4 R10"); // fetch prot keeps data side
    apply(1, 3'd1, 2'd2, 2'd0, 32'hA000_0008, "R5");  // store miss
    apply(1, 3'd3, 2'd0, 2'd0, 32'h1, "R4");          // fetch no-exec
    apply(0, 3'd1, 2'd2, 2'd0, 32'hDEAD_0000, "R2");  // no strobe
    apply(1, 3'd0, 2'd1, 2'd0, 32'hBEEF_0000, "R2");  // strobe with success
    apply(1, 3'd4, 2'd0, 2'd2, 32'h2, "R4");          // fetch direct-store
    apply(1, 3'd2, 2'd1, 2'd0, 32'hB000_0010, "R6 R10"); // load prot keeps err_code
    apply(1, 3'd2, 2'd2, 2'd0, 32'hB000_0014, "R6");  // store prot
    apply(1, 3'd4, 2'd1, 2'd1, 32'hC000_0000, "R7 R10"); // fp direct-store
    apply(1, 3'd4, 2'd2, 2'd1, 32'hC000_0100, "R7");
    apply(1, 3'd4, 2'd1, 2'd2, 32'hC100_0000, "R8");  // reservation load
    apply(1, 3'd4, 2'd2, 2'd2, 32'hC100_0004, "R8");  // reservation store
    apply(1, 3'd4, 2'd1, 2'd0, 32'hC200_0000, "R8");  // integer load
    apply(1, 3'd4, 2'd2, 2'd3, 32'hC200_0008, "R8");  // external store
    apply(1, 3'd4, 2'd3, 2'd3, 32'hC200_000C, "R8");  // class 3 acts as load
    apply(1, 3'd5, 2'd1, 2'd0, 32'hE000_0000, "R9");
    apply(1, 3'd6, 2'd0, 2'd0, 32'hE000_0004, "R9");
    apply(1, 3'd7, 2'd2, 2'd0, 32'hE000_0008, "R9");
    apply(1, 3'd3, 2'd2, 2'd0, 32'hE000_000C, "R9 R10"); // data no-exec
    apply(0, 3'd0, 2'd0, 2'd0, 32'h0, "R2");
    apply(1, 3'd1, 2'd0, 2'd0, 32'hF000_0000, "R3 R10");
    apply(0, 3'd0, 2'd0, 2'd0, 32'h0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule